// File: doc/BRIEF.md
# Keyed-restart watchdog timer on an APB slave port

The block is a watchdog counter that a processor programs and services through a zero-wait-state APB slave port. Once enabled, a down-counter is loaded with a power-of-two period chosen by a 4-bit selector. It then falls by one each clock. Software must keep restarting it by writing a fixed key value. If the count runs out, the block responds in one of two ways. It can drive a system reset pulse at once. Or it can first raise an interrupt, reload, and pulse reset only if a second period passes with that interrupt still pending.

The period is `2^(BASE_EXP+sel)` clocks. The counter loads `2^(BASE_EXP+sel)-1` and the response fires on the clock after it reaches zero. One selector is used when the block is switched on. A second selector is used for every reload after that. The reset pulse length is chosen by a 3-bit code. While the pulse is high the counter is frozen and restart writes are dropped. The APB port never stalls: `pready` is always high, so every transfer completes in its access phase.

Top module: `wdog_apb`

## Requirements
- R1: After reset every register reads zero, the count is zero, and both `irq_o` and `wdt_rst_o` are low.
- R2: A control write that sets bit 0 while the block is off loads the count with `2^(BASE_EXP+F)-1`, where F is timeout bits 7:4. While enabled and idle the count then drops by one per clock.
- R3: With control bit 0 clear the count holds its value, and both outputs are low from the cycle after the disabling write.
- R4: In direct mode (control bit 1 = 0), the clock after the count is seen at zero starts the reset pulse.
- R5: The reset pulse lasts exactly `2^(P+1)` clocks, where P is control bits 4:2. On the clock that ends it, the count reloads with `2^(BASE_EXP+S)-1`, where S is timeout bits 3:0.
- R6: In two-stage mode (control bit 1 = 1), an expiry with no interrupt pending raises `irq_o` and reloads the running period. An expiry with the interrupt still pending starts the reset pulse instead.
- R7: A write whose low byte is 0x76 to offset 0x0C reloads the running period and clears the interrupt. Any other low byte has no effect.
- R8: Restart writes made while the reset pulse is high are dropped, and the count stays at zero until the pulse ends.
- R9: Offset 0x10 bit 0 reads the pending interrupt. A read of offset 0x14 clears it; if an expiry sets the interrupt in the same clock, the set wins.
- R10: Offset 0x00 reads back control bits 4:0, offset 0x04 reads back timeout bits 7:0, and offset 0x08 reads the live count.
- R11: In two-stage mode, if the interrupt is cleared before the next expiry, that expiry raises the interrupt again and does not reset.
- R12: `pready` is high on every access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Always high (no wait states) |
| irq_o | output | 1 | First-stage interrupt, active high |
| wdt_rst_o | output | 1 | System reset pulse, active high |

## Verification
The bench targets several corner cases.

- Pulse length at several codes. A length off by one would shift the first reload and show up at once in the per-clock comparison.
- A restart written in the middle of a pulse. A design that accepted it would show a nonzero count while reset is still high.
- A second expiry in two-stage mode, both with the interrupt left pending and with it cleared first. A design that ignored the pending state would either never reset or reset too early.
- A key with the right low byte but junk upper bits, and a near-miss key. These test whether the decode looks only at the low byte.
- Disabling the block. A design that kept counting after disable would show a changing count on reads.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [7:0] KICK_KEY = 8'h76;

  localparam int OFS_CTRL = 'h00;
  localparam int OFS_TMO  = 'h04;
  localparam int OFS_CNT  = 'h08;
  localparam int OFS_KICK = 'h0C;
  localparam int OFS_STAT = 'h10;
  localparam int OFS_ICLR = 'h14;

  // control word, bit 0 = enable, bit 1 = two-stage, bits 4:2 = pulse code
  typedef struct packed {
    logic [2:0] pw;
    logic       mode;
    logic       en;
  } ctrl_t;

  // timeout word, bits 7:4 = first-load selector, bits 3:0 = reload selector
  typedef struct packed {
    logic [3:0] first;
    logic [3:0] run;
  } tmo_t;

  function automatic logic [63:0] period_m1(input int unsigned base, input logic [3:0] sel);
    return (64'd1 << (base + 32'(sel))) - 64'd1;
  endfunction

endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              irq_vis,
  output ctrl_t             ctrl,
  output tmo_t              tmo,
  output logic              en_rise,
  output logic              kick_req,
  output logic              irq_clr
);

  logic wr, rd;
  logic hit_ctrl, hit_tmo, hit_cnt, hit_kick, hit_stat, hit_iclr;
  logic [31:0] cnt32;
  logic unused_wdata;

  assign wr = psel & penable & pwrite;
  assign rd = psel & penable & ~pwrite;

  assign hit_ctrl = (paddr == ADDR_W'(OFS_CTRL));
  assign hit_tmo  = (paddr == ADDR_W'(OFS_TMO));
  assign hit_cnt  = (paddr == ADDR_W'(OFS_CNT));
  assign hit_kick = (paddr == ADDR_W'(OFS_KICK));
  assign hit_stat = (paddr == ADDR_W'(OFS_STAT));
  assign hit_iclr = (paddr == ADDR_W'(OFS_ICLR));

  assign unused_wdata = ^pwdata[31:8];

  assign en_rise  = wr & hit_ctrl & pwdata[0] & ~ctrl.en;
  assign kick_req = wr & hit_kick & (pwdata[7:0] == KICK_KEY);
  assign irq_clr  = rd & hit_iclr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      tmo  <= '0;
    end else if (wr) begin
      if (hit_ctrl) ctrl <= ctrl_t'(pwdata[4:0]);
      if (hit_tmo)  tmo  <= tmo_t'(pwdata[7:0]);
    end
  end

  always_comb begin
    cnt32 = '0;
    cnt32[CNT_W-1:0] = cnt;
  end

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      if (hit_ctrl) prdata[4:0] = ctrl;
      if (hit_tmo)  prdata[7:0] = tmo;
      if (hit_cnt)  prdata      = cnt32;
      if (hit_stat) prdata[0]   = irq_vis;
    end
  end

  // R10: a control write is visible on the next clock
  a_r10_ctrl_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_ctrl) |=> (ctrl == $past(pwdata[4:0])));

endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PW_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            fire,
  input  logic [PW_W-1:0] code,
  output logic            busy,
  output logic            done
);

  localparam int REM_W = 1 << PW_W;

  logic [REM_W-1:0] rem;
  logic [REM_W:0]   len;
  logic [REM_W-1:0] len_m1;

  assign len    = ({{REM_W{1'b0}}, 1'b1}) << ({1'b0, code} + 1'b1);
  assign len_m1 = REM_W'(len - 1'b1);
  assign done   = busy & (rem == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      rem  <= '0;
    end else if (!en) begin
      busy <= 1'b0;
      rem  <= '0;
    end else if (fire && !busy) begin
      busy <= 1'b1;
      rem  <= len_m1;
    end else if (busy) begin
      if (rem == '0) busy <= 1'b0;
      else           rem  <= rem - 1'b1;
    end
  end

  // R5: the pulse begins right after a fire request and stops after its last cycle
  a_r5_start: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && en && !busy) |=> busy);
  a_r5_end: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  tmo_t             tmo,
  input  logic             en_rise,
  input  logic             kick_req,
  input  logic             irq_clr,
  input  logic             busy,
  input  logic             done,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             fire
);

  logic [CNT_W-1:0] first_ld, run_ld;
  logic zero, kick_ok, expire, set_irq;

  assign first_ld = CNT_W'(period_m1(BASE_EXP, tmo.first));
  assign run_ld   = CNT_W'(period_m1(BASE_EXP, tmo.run));

  assign zero    = (cnt == '0);
  assign kick_ok = ctrl.en & ~busy & kick_req;
  assign expire  = ctrl.en & ~busy & ~kick_req & zero;
  assign set_irq = expire & ctrl.mode & ~irq;
  assign fire    = expire & ~set_irq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (en_rise) begin
      cnt <= first_ld;
    end else if (ctrl.en) begin
      if (busy) begin
        if (done) cnt <= run_ld;
      end else if (kick_ok) begin
        cnt <= run_ld;
      end else if (zero) begin
        if (set_irq) cnt <= run_ld;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                irq <= 1'b0;
    else if (!ctrl.en)         irq <= 1'b0;
    else if (set_irq)          irq <= 1'b1;
    else if (kick_ok || irq_clr) irq <= 1'b0;
  end

  // R2: an enabled idle counter steps down by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.en && !busy && !kick_req && !zero) |=> (cnt == $past(cnt) - 1'b1));
  // R3: a disabled counter does not move
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.en && !en_rise) |=> $stable(cnt));
  // R6: in two-stage mode a reset is only requested with the interrupt pending
  a_r6_irq_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctrl.mode) |-> irq);
  // R7: an accepted key reloads and clears
  a_r7_kick: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> (cnt == $past(run_ld) && !irq));
  // R8: the count is frozen while the pulse runs
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && ctrl.en) |=> $stable(cnt));

endmodule

// File: rtl/wdog_apb.sv
module wdog_apb
  import wdog_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int CNT_W    = 32,
  parameter int BASE_EXP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              irq_o,
  output logic              wdt_rst_o
);

  localparam int PW_W = 3;

  ctrl_t            ctrl;
  tmo_t             tmo;
  logic             en_rise, kick_req, irq_clr;
  logic [CNT_W-1:0] cnt;
  logic             irq, fire, busy, done;

  assign pready    = 1'b1;
  assign irq_o     = irq & ctrl.en;
  assign wdt_rst_o = busy & ctrl.en;

  wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .cnt(cnt), .irq_vis(irq_o),
    .ctrl(ctrl), .tmo(tmo), .en_rise(en_rise), .kick_req(kick_req), .irq_clr(irq_clr)
  );

  wdog_core #(.CNT_W(CNT_W), .BASE_EXP(BASE_EXP)) u_core (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tmo(tmo), .en_rise(en_rise),
    .kick_req(kick_req), .irq_clr(irq_clr), .busy(busy), .done(done),
    .cnt(cnt), .irq(irq), .fire(fire)
  );

  wdog_pulse #(.PW_W(PW_W)) u_pulse (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .fire(fire), .code(ctrl.pw),
    .busy(busy), .done(done)
  );

  // R4: the reset output only rises on an expiry request
  a_r4_rst_from_fire: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_rst_o) |-> $past(fire));

endmodule

// File: tb/tb_wdog_apb.sv
module tb_wdog_apb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, irq_o, wdt_rst_o;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_apb #(.ADDR_W(12), .CNT_W(32), .BASE_EXP(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
  );

  // behavioural reference
  longint m_cnt;
  int     m_left, m_pw, m_first, m_run;
  bit     m_en, m_mode, m_irq;
  bit     b_wr, b_rd, b_rise, b_kick, b_clr;

  function automatic longint per(input int sel);
    return longint'(1) << (BASE + sel);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_left = 0; m_pw = 0; m_first = 0; m_run = 0;
      m_en = 0; m_mode = 0; m_irq = 0;
    end else begin
      b_wr   = psel && penable && pwrite;
      b_rd   = psel && penable && !pwrite;
      b_rise = b_wr && paddr == 12'h000 && pwdata[0] && !m_en;
      b_kick = b_wr && paddr == 12'h00C && pwdata[7:0] == 8'h76;
      b_clr  = b_rd && paddr == 12'h014;
      if (b_rise) begin
        m_cnt = per(m_first) - 1; m_irq = 0; m_left = 0;
      end else if (!m_en) begin
        m_irq = 0; m_left = 0;
      end else if (m_left > 0) begin
        if (m_left == 1) m_cnt = per(m_run) - 1;
        m_left--;
        if (b_clr) m_irq = 0;
      end else if (b_kick) begin
        m_cnt = per(m_run) - 1; m_irq = 0;
      end else if (m_cnt == 0) begin
        if (m_mode && !m_irq) begin
          m_irq = 1; m_cnt = per(m_run) - 1;
        end else begin
          m_left = 1 << (m_pw + 1);
          if (b_clr) m_irq = 0;
        end
      end else begin
        m_cnt--;
        if (b_clr) m_irq = 0;
      end
      if (b_wr && paddr == 12'h000) begin
        m_en = pwdata[0]; m_mode = pwdata[1]; m_pw = int'(pwdata[4:2]);
      end
      if (b_wr && paddr == 12'h004) begin
        m_run = int'(pwdata[3:0]); m_first = int'(pwdata[7:4]);
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h000: return {27'd0, 3'(m_pw), m_mode, m_en};
      12'h004: return {24'd0, 4'(m_first), 4'(m_run)};
      12'h008: return 32'(m_cnt);
      12'h010: return {31'd0, m_irq && m_en};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison of the outputs
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4", {31'd0, wdt_rst_o}, {31'd0, (m_left > 0) && m_en});
      chk("R6", {31'd0, irq_o}, {31'd0, m_irq && m_en});
    end
  end

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, input string tag);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1;
    chk(tag, prdata, m_read(a));
    chk("R12", {31'd0, pready}, 32'd1);
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    // R1: reset state
    chk("R1", {30'd0, irq_o, wdt_rst_o}, 32'd0);
    apb_rd(12'h000, "R1");
    apb_rd(12'h004, "R1");
    apb_rd(12'h008, "R1");
    apb_rd(12'h010, "R1");

    // R10/R2: program and enable in direct mode, pulse code 0
    apb_wr(12'h004, 32'h0000_0031);
    apb_rd(12'h004, "R10");
    apb_wr(12'h000, 32'h0000_0001);
    apb_rd(12'h000, "R10");
    apb_rd(12'h008, "R2");
    idle(5);
    apb_rd(12'h008, "R2");
    // R4/R5: wait for the pulse and the reload after it
    while (m_left == 0) @(negedge clk);
    chk("R4", {31'd0, wdt_rst_o}, 32'd1);
    while (m_left > 0) @(negedge clk);
    apb_rd(12'h008, "R5");

    // R7: near-miss key ignored, key with junk upper bits accepted
    apb_wr(12'h00C, 32'h0000_0077);
    apb_rd(12'h008, "R7");
    apb_wr(12'h00C, 32'h1234_5676);
    apb_rd(12'h008, "R7");

    // R5/R8: longer pulse, restart inside it dropped
    apb_wr(12'h000, 32'h0000_0009);
    while (m_left == 0) @(negedge clk);
    apb_wr(12'h00C, 32'h0000_0076);
    apb_rd(12'h008, "R8");
    while (m_left > 0) @(negedge clk);
    apb_rd(12'h008, "R5");
    apb_wr(12'h000, 32'h0000_001D);
    while (m_left == 0) @(negedge clk);
    while (m_left > 0) @(negedge clk);
    apb_rd(12'h008, "R5");

    // R3: disable holds count, outputs low
    apb_wr(12'h000, 32'h0000_0000);
    apb_rd(12'h008, "R3");
    idle(4);
    apb_rd(12'h008, "R3");
    chk("R3", {30'd0, irq_o, wdt_rst_o}, 32'd0);

    // R6/R9: two-stage mode, interrupt then reset
    apb_wr(12'h000, 32'h0000_0003);
    while (!m_irq) @(negedge clk);
    apb_rd(12'h010, "R9");
    chk("R6", {30'd0, irq_o, wdt_rst_o}, 32'd2);
    while (m_left == 0) @(negedge clk);
    chk("R6", {31'd0, wdt_rst_o}, 32'd1);
    while (m_left > 0) @(negedge clk);

    // R9/R11: clear by read, next expiry raises irq again without reset
    apb_rd(12'h014, "R9");
    @(negedge clk);
    chk("R9", {31'd0, irq_o}, 32'd0);
    apb_rd(12'h010, "R9");
    while (!m_irq) @(negedge clk);
    chk("R11", {30'd0, irq_o, wdt_rst_o}, 32'd2);

    // R7: key clears the pending interrupt
    apb_wr(12'h00C, 32'h0000_0076);
    @(negedge clk);
    chk("R7", {31'd0, irq_o}, 32'd0);
    apb_rd(12'h008, "R7");

    // R3: disable while interrupt pending
    idle(20);
    apb_wr(12'h000, 32'h0000_0002);
    idle(3);
    chk("R3", {30'd0, irq_o, wdt_rst_o}, 32'd0);
    apb_rd(12'h010, "R3");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule